// File: doc/BRIEF.md
# I2C Slave Controller with Interrupt Status

This block is the target side of a two-wire serial bus. It watches the open-drain clock and data lines, finds START, repeated START and STOP conditions, and compares the first byte of each transfer against a programmed 7-bit address. An optional general-call address of zero can also be matched. Once addressed, it either receives bytes from the bus master or sends bytes back to it.

A single byte-wide data buffer is the only data path the host can reach. Received bytes land in the buffer. Bytes to be sent are written into the buffer, and the engine copies them into a private shift register. An eight-bit status word reports the state of the transfer, and one interrupt line is the OR of a fixed subset of its bits.

The host side is a plain register interface with write, read and status-read strobes. Flow control happens on the bus, not at the host port. The controller stretches SCL (holds it low) in two cases:
- in transmit, while the host has not supplied the next byte;
- in receive, while the previous byte has not yet been read.

Top module: `i2cs_ctrl`

## Requirements
- R1: After reset the status word and interrupt are 0, the data buffer reads 0, and both line drivers (`scl_oe`, `sda_oe`) are off.
- R2: When the first byte after a START holds the programmed address in bits 7..1, the controller acknowledges it (SDA low on the ninth clock). It sets slave-address-match (status bit 5) and copies bit 0 (1 = master reads) into the direction bit (status bit 3). Any other address is not acknowledged and leaves the status word unchanged.
- R3: With `gc_en` set, address 0 with a write direction is acknowledged and sets general-call (status bit 4). With `gc_en` clear it is not acknowledged. General-call and direction keep their values until the next address match.
- R4: A byte written by the master, most significant bit first, is acknowledged, placed in the data buffer and sets receive-data-full (status bit 6). A host data read clears that bit.
- R5: A host data write is ignored while the controller is addressed for a master write. The buffer content and transmit-data-empty do not change.
- R6: If receive-data-full is still set when the eighth bit of a received byte ends, SCL is held low. The byte is acknowledged only after the host reads the buffer.
- R7: In a master-read transfer, the buffer byte is sent most significant bit first. Transmit-data-empty (status bit 7) is set when the buffer is copied to the shifter, or when a read address matches while no byte is pending. A host data write clears it.
- R8: If no byte is pending when the next transmit byte is due, SCL is held low until the host writes the buffer.
- R9: A Not Acknowledge from the master after a sent byte sets not-acknowledge (status bit 0). The controller then releases SDA for the rest of the transfer.
- R10: A STOP or repeated START that ends an addressed transfer sets stop/restart (status bit 1). A status read clears stop/restart, not-acknowledge and slave-address-match.
- R11: `irq` is high exactly when any of status bits 7, 6, 5, 2, 1 or 0 is set. Bits 4 and 3 never raise it. Arbitration-lost (status bit 2) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretching) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| own_addr | input | 7 | Programmed slave address |
| gc_en | input | 1 | Enables answering the general-call address 0 |
| data_wr | input | 1 | Host write strobe for the data buffer |
| data_wdata | input | 8 | Host write data |
| data_rd | input | 1 | Host read strobe for the data buffer (clears receive-data-full) |
| data_rdata | output | 8 | Current data buffer content |
| stat_rd | input | 1 | Host read strobe for the status word (clears bits 5, 1, 0) |
| status | output | 8 | Status word: 7 tx-empty, 6 rx-full, 5 addr-match, 4 general-call, 3 direction, 2 arb-lost, 1 stop/restart, 0 not-ack |
| irq | output | 1 | Combined interrupt |

## Verification
Line inputs pass through a two-flop synchroniser and a two-sample filter. The controller therefore reacts to an SCL edge about four clocks after it appears: it changes SDA, starts a stretch or issues a status event at that point. The bench's bus master holds every line level for sixteen clocks, so each slave response has settled before the master looks at it.

Host strobes change the status word within two clocks. The bench reads status and buffer values at least several clocks after the bus event or strobe that produced them, one time unit after a rising edge.

Stretch checks wait forty clocks with SCL released by the master and confirm the line is still low. The strobe that should end the stretch is then applied.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int SB_TDE = 7;
  localparam int SB_RDF = 6;
  localparam int SB_SAM = 5;
  localparam int SB_GCA = 4;
  localparam int SB_DIR = 3;
  localparam int SB_ARB = 2;
  localparam int SB_SPR = 1;
  localparam int SB_NAK = 0;
  localparam logic [7:0] IRQ_MASK = 8'hE7;

  typedef enum logic [3:0] {
    E_IDLE, E_ADDR, E_ADDR_ACK, E_RX, E_RX_HOLD, E_RX_ACK,
    E_TX, E_TX_HOLD, E_TX_ACK, E_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int TOP = SYNC_STAGES - 1;
  logic [TOP:0] sync_q;
  logic         prev_q;
  logic         filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[TOP-1:0], line_i};
      prev_q <= sync_q[TOP];
      if (sync_q[TOP] == prev_q) filt_q <= prev_q;
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              tx_pend,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rdf,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_busy,
  output logic              ev_match,
  output logic              ev_gc,
  output logic              ev_dir,
  output logic              ev_push,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ev_load,
  output logic              ev_tde,
  output logic              ev_nak,
  output logic              ev_spr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  eng_state_t        state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q, engaged_q, nak_q;

  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rw, own_hit, gc_hit;

  assign rx_addr = shreg_q[DATA_W-1:1];
  assign rx_rw   = shreg_q[0];
  assign own_hit = (rx_addr == own_addr);
  assign gc_hit  = gc_en && (rx_addr == '0) && !rx_rw;
  assign rx_busy = engaged_q && !dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= E_IDLE;
      shreg_q   <= '0;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      engaged_q <= 1'b0;
      nak_q     <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rx_byte   <= '0;
      ev_match  <= 1'b0;
      ev_gc     <= 1'b0;
      ev_dir    <= 1'b0;
      ev_push   <= 1'b0;
      ev_load   <= 1'b0;
      ev_tde    <= 1'b0;
      ev_nak    <= 1'b0;
      ev_spr    <= 1'b0;
    end else begin
      ev_match <= 1'b0;
      ev_push  <= 1'b0;
      ev_load  <= 1'b0;
      ev_tde   <= 1'b0;
      ev_nak   <= 1'b0;
      ev_spr   <= 1'b0;
      if (start_ev || stop_ev) begin
        state_q   <= start_ev ? E_ADDR : E_IDLE;
        cnt_q     <= '0;
        scl_oe    <= 1'b0;
        sda_oe    <= 1'b0;
        ev_spr    <= engaged_q;
        engaged_q <= 1'b0;
      end else begin
        unique case (state_q)
          E_ADDR, E_RX: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[DATA_W-2:0], sda_f};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              cnt_q <= '0;
              if (state_q == E_ADDR) begin
                if (own_hit || gc_hit) begin
                  sda_oe    <= 1'b1;
                  state_q   <= E_ADDR_ACK;
                  ev_match  <= 1'b1;
                  ev_gc     <= gc_hit;
                  ev_dir    <= rx_rw;
                  dir_q     <= rx_rw;
                  engaged_q <= 1'b1;
                  ev_tde    <= rx_rw && !tx_pend;
                end else begin
                  state_q <= E_SKIP;
                end
              end else if (!rdf) begin
                rx_byte <= shreg_q;
                ev_push <= 1'b1;
                sda_oe  <= 1'b1;
                state_q <= E_RX_ACK;
              end else begin
                scl_oe  <= 1'b1;
                state_q <= E_RX_HOLD;
              end
            end
          end
          E_RX_HOLD: begin
            if (!rdf) begin
              rx_byte <= shreg_q;
              ev_push <= 1'b1;
              sda_oe  <= 1'b1;
              scl_oe  <= 1'b0;
              state_q <= E_RX_ACK;
            end
          end
          E_RX_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              state_q <= E_RX;
            end
          end
          E_ADDR_ACK, E_TX_ACK: begin
            if (scl_rise) nak_q <= sda_f;
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt_q  <= '0;
              if (state_q == E_ADDR_ACK && !dir_q) begin
                state_q <= E_RX;
              end else if (state_q == E_TX_ACK && nak_q) begin
                ev_nak  <= 1'b1;
                state_q <= E_SKIP;
              end else if (tx_pend) begin
                shreg_q <= tx_byte;
                sda_oe  <= ~tx_byte[DATA_W-1];
                ev_load <= 1'b1;
                ev_tde  <= 1'b1;
                state_q <= E_TX;
              end else begin
                scl_oe  <= 1'b1;
                state_q <= E_TX_HOLD;
              end
            end
          end
          E_TX_HOLD: begin
            if (tx_pend) begin
              shreg_q <= tx_byte;
              sda_oe  <= ~tx_byte[DATA_W-1];
              ev_load <= 1'b1;
              ev_tde  <= 1'b1;
              scl_oe  <= 1'b0;
              cnt_q   <= '0;
              state_q <= E_TX;
            end
          end
          E_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              sda_oe  <= 1'b0;
              cnt_q   <= '0;
              state_q <= E_TX_ACK;
            end else if (scl_fall && cnt_q != '0) begin
              shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
              sda_oe  <= ~shreg_q[DATA_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_status.sv
module i2cs_status
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              rx_busy,
  input  logic              ev_match,
  input  logic              ev_gc,
  input  logic              ev_dir,
  input  logic              ev_push,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ev_load,
  input  logic              ev_tde,
  input  logic              ev_nak,
  input  logic              ev_spr,
  output logic [DATA_W-1:0] buf_q,
  output logic              tx_pend,
  output logic              rdf,
  output logic [7:0]        status,
  output logic              irq
);
  logic tde_q, sam_q, gca_q, dir_q, spr_q, nak_q;
  logic wr_ok;

  assign wr_ok = data_wr && !rx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      tx_pend <= 1'b0;
      rdf     <= 1'b0;
      tde_q   <= 1'b0;
      sam_q   <= 1'b0;
      gca_q   <= 1'b0;
      dir_q   <= 1'b0;
      spr_q   <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      if (ev_load) tx_pend <= 1'b0;
      if (ev_tde)  tde_q   <= 1'b1;
      if (wr_ok) begin
        buf_q   <= data_wdata;
        tx_pend <= 1'b1;
        tde_q   <= 1'b0;
      end
      if (data_rd) rdf <= 1'b0;
      if (ev_push) begin
        buf_q <= rx_byte;
        rdf   <= 1'b1;
      end
      if (stat_rd) begin
        sam_q <= 1'b0;
        spr_q <= 1'b0;
        nak_q <= 1'b0;
      end
      if (ev_match) begin
        sam_q <= 1'b1;
        gca_q <= ev_gc;
        dir_q <= ev_dir;
      end
      if (ev_spr) spr_q <= 1'b1;
      if (ev_nak) nak_q <= 1'b1;
    end
  end

  always_comb begin
    status         = '0;
    status[SB_TDE] = tde_q;
    status[SB_RDF] = rdf;
    status[SB_SAM] = sam_q;
    status[SB_GCA] = gca_q;
    status[SB_DIR] = dir_q;
    status[SB_ARB] = 1'b0;
    status[SB_SPR] = spr_q;
    status[SB_NAK] = nak_q;
  end

  assign irq = |(status & IRQ_MASK);
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              data_wr,
  input  logic [ADDR_W:0]   data_wdata,
  input  logic              data_rd,
  output logic [ADDR_W:0]   data_rdata,
  input  logic              stat_rd,
  output logic [7:0]        status,
  output logic              irq
);
  localparam int DATA_W = ADDR_W + 1;
  localparam int LINES  = 2;

  logic [LINES-1:0] raw_lines, filt_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic tx_pend, rdf, rx_busy;
  logic ev_match, ev_gc, ev_dir, ev_push, ev_load, ev_tde, ev_nak, ev_spr;
  logic [DATA_W-1:0] rx_byte;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g])
    );
  end

  i2cs_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_f(filt_lines[1]), .sda_f(filt_lines[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(filt_lines[0]),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .gc_en(gc_en),
    .tx_pend(tx_pend), .tx_byte(data_rdata), .rdf(rdf),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_busy(rx_busy),
    .ev_match(ev_match), .ev_gc(ev_gc), .ev_dir(ev_dir),
    .ev_push(ev_push), .rx_byte(rx_byte), .ev_load(ev_load),
    .ev_tde(ev_tde), .ev_nak(ev_nak), .ev_spr(ev_spr)
  );

  i2cs_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd),
    .stat_rd(stat_rd), .rx_busy(rx_busy),
    .ev_match(ev_match), .ev_gc(ev_gc), .ev_dir(ev_dir),
    .ev_push(ev_push), .rx_byte(rx_byte), .ev_load(ev_load),
    .ev_tde(ev_tde), .ev_nak(ev_nak), .ev_spr(ev_spr),
    .buf_q(data_rdata), .tx_pend(tx_pend), .rdf(rdf),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/i2cs_ctrl_checker.sv
module i2cs_ctrl_checker
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       data_wr,
  input logic       data_rd,
  input logic       stat_rd,
  input logic [7:0] data_rdata,
  input logic [7:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_busy,
  input logic       ev_push,
  input logic       ev_nak,
  input logic       ev_spr
);
  // R5: a blocked host write leaves the buffer alone
  a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && rx_busy && !ev_push |=> $stable(data_rdata));

  // R6: a received byte is only pushed into an empty buffer
  a_r6_push_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> !status[SB_RDF]);

  // R8: stretching only while a byte is awaited or just supplied
  a_r8_stretch_reason: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (status[SB_RDF] || status[SB_TDE] || $past(data_rd) || $past(data_wr)));

  // R9: SDA is released when the master declines a byte
  a_r9_nak_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak |-> !sda_oe);

  // R10: a status read clears the event bits
  a_r10_clear_nak: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ev_nak |=> !status[SB_NAK]);
  a_r10_clear_spr: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ev_spr |=> !status[SB_SPR]);
endmodule

bind i2cs_ctrl i2cs_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_rd(data_rd),
  .stat_rd(stat_rd), .data_rdata(data_rdata), .status(status),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_busy(rx_busy),
  .ev_push(ev_push), .ev_nak(ev_nak), .ev_spr(ev_spr)
);

// File: tb/i2cs_ctrl_bench.sv
module i2cs_ctrl_bench;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int NV = 5;
  // {addr[24:18], gc_en[17], data[16:9], addr_ack[8], status_after_stop[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {7'h5A, 1'b0, 8'hC3, 1'b1, 8'h62},
    {7'h33, 1'b0, 8'h00, 1'b0, 8'h00},
    {7'h00, 1'b1, 8'h7E, 1'b1, 8'h72},
    {7'h00, 1'b0, 8'h11, 1'b0, 8'h10},
    {7'h5A, 1'b1, 8'h81, 1'b1, 8'h62}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic gc_en = 1'b0;
  logic data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] data_wdata = '0;
  logic scl_oe, sda_oe, irq;
  logic [7:0] data_rdata, status;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2cs_ctrl u_i2cs_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc_en),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd),
    .data_rdata(data_rdata), .stat_rd(stat_rd), .status(status), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    for (int k = 0; k < 5000 && !scl_line; k++) tick(1);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic m_bit_out(input logic b);
    sda_m = b; tick(H); scl_m = 1'b1; wait_scl_high(); tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic m_bit_in(output logic b);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; wait_scl_high(); tick(H / 2);
    b = sda_line; tick(H / 2); scl_m = 1'b0; tick(H);
  endtask

  task automatic m_byte_out(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
    m_bit_in(a);
    ack = !a;
  endtask

  task automatic m_byte_in(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_bit_in(b); v[i] = b; end
    m_bit_out(!give_ack);
  endtask

  task automatic h_write(input logic [7:0] v);
    data_wdata = v; data_wr = 1'b1; tick(1); data_wr = 1'b0; tick(2);
  endtask

  task automatic h_read_data(output logic [7:0] v);
    v = data_rdata; data_rd = 1'b1; tick(1); data_rd = 1'b0; tick(2);
  endtask

  task automatic h_read_status(output logic [7:0] v);
    v = status; stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack, b;
    logic [7:0] s, d, v8;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 line drivers", {scl_oe, sda_oe}, 2'b00);
    chk("R1 buffer", data_rdata, 8'h00);

    // Table walk: R2 R3 R4 R10 R11
    for (int i = 0; i < NV; i++) begin
      gc_en = VEC[i][17];
      m_start();
      m_byte_out({VEC[i][24:18], 1'b0}, ack);
      chk("R2/R3 address ack", ack, VEC[i][8]);
      if (ack) begin
        m_byte_out(VEC[i][16:9], ack);
        chk("R4 data ack", ack, 1'b1);
      end
      m_stop();
      tick(4);
      chk("R10/R11 arb-lost zero", status[2], 1'b0);
      chk("R11 irq", irq, |(VEC[i][7:0] & 8'hE7));
      h_read_status(s);
      chk("R2/R3/R4/R10 status", s, VEC[i][7:0]);
      if (VEC[i][8]) begin
        h_read_data(d);
        chk("R4 received byte", d, VEC[i][16:9]);
      end
      chk("R10 status after reads", status, VEC[i][7:0] & 8'h18);
      chk("R11 irq after reads", irq, 1'b0);
    end

    // R5 and R6: blocked write, then receive stretch
    gc_en = 1'b0;
    m_start();
    m_byte_out({OWN, 1'b0}, ack);
    chk("R2 ack write", ack, 1'b1);
    h_write(8'hEE);
    chk("R5 buffer unchanged", data_rdata, 8'h81);
    chk("R5 tde unchanged", status[7], 1'b0);
    m_byte_out(8'h24, ack);
    chk("R4 ack first byte", ack, 1'b1);
    tick(4);
    chk("R4 rdf set", status[6], 1'b1);
    for (int i = 7; i >= 0; i--) m_bit_out(v8_const(i));
    fork
      m_bit_in(b);
      begin
        tick(40);
        chk("R6 scl held", scl_line, 1'b0);
        h_read_data(d);
        chk("R6 first byte", d, 8'h24);
      end
    join
    chk("R6 late ack", b, 1'b0);
    tick(4);
    chk("R6 second byte", data_rdata, 8'h99);
    m_stop();
    tick(4);
    h_read_status(s);
    chk("R10 status after write", s, 8'h62);
    h_read_data(d);

    // R7 R8 R9: slave transmit
    m_start();
    m_byte_out({OWN, 1'b1}, ack);
    chk("R2 ack read", ack, 1'b1);
    h_read_status(s);
    chk("R7 status at read match", s, 8'hA8);
    fork
      m_bit_in(b);
      begin
        tick(40);
        chk("R8 scl held", scl_line, 1'b0);
        h_write(8'hA5);
      end
    join
    v8 = '0;
    v8[7] = b;
    h_write(8'h3C);
    tick(2);
    chk("R7 tde cleared by write", status[7], 1'b0);
    for (int i = 6; i >= 0; i--) begin m_bit_in(b); v8[i] = b; end
    chk("R7 first byte sent", v8, 8'hA5);
    m_bit_out(1'b0);
    m_byte_in(v8, 1'b0);
    chk("R7 second byte sent", v8, 8'h3C);
    tick(4);
    chk("R9 nak bit", status[0], 1'b1);
    chk("R9 irq", irq, 1'b1);
    chk("R9 sda released", sda_oe, 1'b0);
    m_stop();
    tick(4);
    h_read_status(s);
    chk("R9/R10 status after read transfer", s, 8'h8B);
    h_write(8'h00);
    chk("R11 only dir left", status, 8'h08);
    chk("R11 dir raises no irq", irq, 1'b0);

    // R10: repeated START ends an addressed transfer
    m_start();
    m_byte_out({OWN, 1'b0}, ack);
    chk("R2 ack before restart", ack, 1'b1);
    m_start();
    m_byte_out({7'h33, 1'b0}, ack);
    chk("R2 nack other address", ack, 1'b0);
    m_stop();
    tick(4);
    chk("R10 restart status", status, 8'h22);
    chk("R11 restart irq", irq, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic v8_const(input int i);
    logic [7:0] c = 8'h99;
    return c[i];
  endfunction
endmodule